// File: doc/BRIEF.md
# PS/2 Port Register Interface

This block is the memory-mapped register front end for one PS/2 keyboard or mouse port. A processor reaches it over a simple 32-bit word-addressed bus with separate read and write strobes inside a 4 KB window. Through it software sets the port's control bits, programs a clock divisor, polls status and interrupt state, reads received bytes, and queues bytes for transmission.

On the device side, a line-level serializer delivers each received byte with a one-cycle valid strobe. The block holds that byte as pending until software reads the data register. Bytes written by software leave through a one-cycle transmit strobe. A single interrupt output combines a gated receive condition with a bit that forces the line high. The top of the window holds eight read-only identification bytes.

Bus reads are combinational. `busRdata` is valid in the same cycle that `busRd` is high. Side effects of a read or write take effect at the next rising clock edge.

Top module: `ps2_port_regs`

## Requirements
- R1: After reset, control, divisor, holding byte and pending flag are all zero. `irq` and `txValid` are low.
- R2: Control (offset 0x00) and divisor (offset 0x0C) each store the low 8 bits of a write and read them back. Their upper bits read as zero.
- R3: A status read (offset 0x04) returns bit 6 = 1 (transmit empty), bit 4 = pending flag, and bit 2 = XOR of all 8 bits of the holding byte. Bits 5, 3, 1, 0 and 31:7 read as zero.
- R4: A cycle with `rxValid` high stores `rxByte` as the pending byte and sets the pending flag. A byte that arrives while one is pending replaces it, and the flag stays set.
- R5: A data read (offset 0x08) with a byte pending returns that byte, copies it into the holding register and clears the flag. With nothing pending it returns the holding byte and changes nothing.
- R6: One cycle after any change of control or pending state, `irq` equals (pending AND control bit 4) OR control bit 3.
- R7: An interrupt-status read (offset 0x10) returns the pending flag in bit 0 and a constant 1 in bit 1. All other bits are zero.
- R8: A data write drives `txValid` high for the following cycle, with `txByte` equal to bits 7:0 of the written word.
- R9: Reads at 0xFE0, 0xFE4 … 0xFFC return 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R10: Reads of unmapped offsets return zero. Writes to status, interrupt status, identification or unmapped offsets change no register and raise no strobe.
- R11: When `rxValid` arrives in the same cycle as a data read of a pending byte, the read returns the old byte and the old byte moves into the holding register. The new byte then becomes pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address within the window |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| txValid | output | 1 | Transmit byte strobe |
| txByte | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision in R11, where a new byte lands on the exact edge at which software consumes the pending one. The directed test first leaves one byte pending. It then raises `rxValid` and the data-read strobe together in a single cycle. It checks the old byte on the bus in that cycle, and afterwards confirms that the flag is still set and that the next data read returns the new byte. The overwrite and force-interrupt paths are reached in a similar way, by ordering bus accesses and receive strobes cycle by cycle.

// File: rtl/ps2_port_pkg.sv
package ps2_port_pkg;

  // Strobes and selects from the decoder to the datapath
  typedef struct packed {
    logic       wrCtrl;
    logic       wrDiv;
    logic       wrData;
    logic       rdData;
    logic       selCtrl;
    logic       selStat;
    logic       selData;
    logic       selDiv;
    logic       selIntSt;
    logic       selId;
    logic [2:0] idIdx;
  } regStrb_t;

  // Control bit positions that drive the interrupt
  localparam int CTRL_FORCE_BIT = 3;
  localparam int CTRL_RXIE_BIT  = 4;

  // Status bit positions
  localparam int STAT_PARITY_BIT  = 2;
  localparam int STAT_RXFULL_BIT  = 4;
  localparam int STAT_TXEMPTY_BIT = 6;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h50;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ps2_port_ctrl.sv
module ps2_port_ctrl
  import ps2_port_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output regStrb_t          strb
);

  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_DATA  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFF_DIV   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFF_INTST = ADDR_W'('h10);
  localparam int ID_HI_W = ADDR_W - 5;

  logic [ADDR_W-1:0] wordAddr;
  logic isCtrl, isStat, isData, isDiv, isIntSt, isId;

  always_comb begin
    wordAddr = {busAddr[ADDR_W-1:2], 2'b00};
    isCtrl   = (wordAddr == OFF_CTRL);
    isStat   = (wordAddr == OFF_STAT);
    isData   = (wordAddr == OFF_DATA);
    isDiv    = (wordAddr == OFF_DIV);
    isIntSt  = (wordAddr == OFF_INTST);
    isId     = (busAddr[ADDR_W-1:5] == {ID_HI_W{1'b1}});

    strb.wrCtrl   = busWr & isCtrl;
    strb.wrDiv    = busWr & isDiv;
    strb.wrData   = busWr & isData;
    strb.rdData   = busRd & isData;
    strb.selCtrl  = isCtrl;
    strb.selStat  = isStat;
    strb.selData  = isData;
    strb.selDiv   = isDiv;
    strb.selIntSt = isIntSt;
    strb.selId    = isId;
    strb.idIdx    = busAddr[4:2];
  end

  // At most one register is selected at any address
  p_one_select_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selCtrl, strb.selStat, strb.selData, strb.selDiv,
              strb.selIntSt, strb.selId}));

  // Only the three writable registers can take a write strobe
  p_write_only_mapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.wrCtrl, strb.wrDiv, strb.wrData}) <= 1);

endmodule

// File: rtl/ps2_port_dp.sv
module ps2_port_dp
  import ps2_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq
);

  logic [CTRL_W-1:0] ctrlQ, ctrlNext;
  logic [DIV_W-1:0]  divQ;
  logic [BYTE_W-1:0] heldQ, heldNext;
  logic [BYTE_W-1:0] pendByteQ, pendByteNext;
  logic              pendQ, pendNext;
  logic              consume;
  logic              irqQ, txValidQ;
  logic [BYTE_W-1:0] txByteQ;

  always_comb begin
    consume      = strb.rdData & pendQ;
    ctrlNext     = strb.wrCtrl ? busWdata[CTRL_W-1:0] : ctrlQ;
    heldNext     = consume ? pendByteQ : heldQ;
    pendByteNext = rxValid ? rxByte : pendByteQ;
    if (rxValid)      pendNext = 1'b1;
    else if (consume) pendNext = 1'b0;
    else              pendNext = pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      divQ      <= '0;
      heldQ     <= '0;
      pendByteQ <= '0;
      pendQ     <= 1'b0;
      irqQ      <= 1'b0;
      txValidQ  <= 1'b0;
      txByteQ   <= '0;
    end else begin
      ctrlQ     <= ctrlNext;
      if (strb.wrDiv) divQ <= busWdata[DIV_W-1:0];
      heldQ     <= heldNext;
      pendByteQ <= pendByteNext;
      pendQ     <= pendNext;
      irqQ      <= (pendNext & ctrlNext[CTRL_RXIE_BIT]) | ctrlNext[CTRL_FORCE_BIT];
      txValidQ  <= strb.wrData;
      if (strb.wrData) txByteQ <= busWdata[BYTE_W-1:0];
    end
  end

  // Read-back mux
  always_comb begin
    busRdata = '0;
    if (strb.selCtrl) begin
      busRdata[CTRL_W-1:0] = ctrlQ;
    end else if (strb.selStat) begin
      busRdata[STAT_TXEMPTY_BIT] = 1'b1;
      busRdata[STAT_RXFULL_BIT]  = pendQ;
      busRdata[STAT_PARITY_BIT]  = ^heldQ;
    end else if (strb.selData) begin
      busRdata[BYTE_W-1:0] = pendQ ? pendByteQ : heldQ;
    end else if (strb.selDiv) begin
      busRdata[DIV_W-1:0] = divQ;
    end else if (strb.selIntSt) begin
      busRdata[0] = pendQ;
      busRdata[1] = 1'b1;
    end else if (strb.selId) begin
      busRdata[7:0] = idByte(strb.idIdx);
    end
  end

  assign txValid = txValidQ;
  assign txByte  = txByteQ;
  assign irq     = irqQ;

  // Interrupt line agrees with registered control and pending state
  p_irq_equation_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqQ == ((pendQ & ctrlQ[CTRL_RXIE_BIT]) | ctrlQ[CTRL_FORCE_BIT]));

  // An incoming byte is always captured and marked pending
  p_rx_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (pendQ && pendByteQ == $past(rxByte)));

  // Consuming read without a new arrival clears pending and fills holding
  p_consume_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdData && pendQ && !rxValid) |=> (!pendQ && heldQ == $past(pendByteQ)));

  // Data read with nothing pending leaves the holding byte alone
  p_idle_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdData && !pendQ) |=> $stable(heldQ));

  // Collision keeps pending set and moves the old byte to holding
  p_collision_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdData && pendQ && rxValid) |=> (pendQ && heldQ == $past(pendByteQ)));

  // A data write produces a transmit strobe carrying its low byte
  p_tx_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (txValidQ && txByte == $past(busWdata[BYTE_W-1:0])));

  // Divisor changes only on its own write
  p_div_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDiv |=> $stable(divQ));

  // Pending is never cleared except by a data read
  p_pend_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !strb.rdData) |=> pendQ);

endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs
  import ps2_port_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq
);

  regStrb_t strb;

  ps2_port_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strb    (strb)
  );

  ps2_port_dp #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .CTRL_W (CTRL_W),
    .DIV_W  (DIV_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .txValid  (txValid),
    .txByte   (txByte),
    .irq      (irq)
  );

endmodule

// File: tb/test_ps2_port_regs.sv
module test_ps2_port_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        txValid;
  logic [7:0]  txByte;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ps2_port_regs i_ps2_port_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxByte(rxByte),
    .txValid(txValid), .txByte(txByte), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #5 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 txValid", {31'b0, txValid}, 32'h0);
    busRead(12'h000, d); chk("R1 ctrl", d, 32'h0);
    busRead(12'h00C, d); chk("R1 div", d, 32'h0);
    busRead(12'h008, d); chk("R1 held", d, 32'h0);
    busRead(12'h004, d); chk("R1 status", d, 32'h40);
    busRead(12'h010, d); chk("R1 intst", d, 32'h2);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    busWrite(12'h000, 32'hA5); busRead(12'h000, d); chk("R2 ctrl", d, 32'hA5);
    busWrite(12'h000, 32'hFFFF_FF62); busRead(12'h000, d); chk("R2 ctrl mask", d, 32'h62);
    busWrite(12'h00C, 32'h1234_563C); busRead(12'h00C, d); chk("R2 div", d, 32'h3C);
    busWrite(12'h000, 32'h0);
  endtask

  task automatic testRxAndIrq();
    logic [31:0] d;
    pushRx(8'h96);
    busRead(12'h004, d); chk("R3 status pending", d, 32'h50);
    busRead(12'h010, d); chk("R7 intst pending", d, 32'h3);
    chk("R6 gated off", {31'b0, irq}, 32'h0);
    busWrite(12'h000, 32'h10);
    chk("R6 rx enabled", {31'b0, irq}, 32'h1);
    busRead(12'h008, d); chk("R5 consume", d, 32'h96);
    chk("R6 drop on consume", {31'b0, irq}, 32'h0);
    busRead(12'h004, d); chk("R3 status even parity", d, 32'h40);
    busRead(12'h008, d); chk("R5 idle read", d, 32'h96);
    pushRx(8'h3C);
    chk("R6 rx raise", {31'b0, irq}, 32'h1);
    pushRx(8'h07);
    busRead(12'h010, d); chk("R4 still pending", d, 32'h3);
    busRead(12'h008, d); chk("R4 overwrite", d, 32'h07);
    busRead(12'h004, d); chk("R3 odd parity", d, 32'h44);
    busWrite(12'h000, 32'h08);
    chk("R6 force", {31'b0, irq}, 32'h1);
    busWrite(12'h000, 32'h00);
    chk("R6 force off", {31'b0, irq}, 32'h0);
  endtask

  task automatic testTx();
    busWrite(12'h008, 32'h0000_01AB);
    chk("R8 txValid", {31'b0, txValid}, 32'h1);
    chk("R8 txByte", {24'b0, txByte}, 32'hAB);
    @(negedge clk);
    chk("R8 single pulse", {31'b0, txValid}, 32'h0);
  endtask

  task automatic testId();
    logic [31:0] d;
    logic [7:0] idExp [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      busRead(12'hFE0 + 12'(i * 4), d);
      chk("R9 id byte", d, {24'b0, idExp[i]});
    end
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busRead(12'h014, d); chk("R10 read 0x14", d, 32'h0);
    busRead(12'h800, d); chk("R10 read 0x800", d, 32'h0);
    busWrite(12'h004, 32'hFFFF_FFFF);
    chk("R10 no tx after stat write", {31'b0, txValid}, 32'h0);
    busWrite(12'h010, 32'hFFFF_FFFF);
    busWrite(12'hFE0, 32'hFFFF_FFFF);
    busWrite(12'h014, 32'hFFFF_FFFF);
    chk("R10 no tx", {31'b0, txValid}, 32'h0);
    chk("R10 no irq", {31'b0, irq}, 32'h0);
    busRead(12'h000, d); chk("R10 ctrl kept", d, 32'h0);
    busRead(12'h00C, d); chk("R10 div kept", d, 32'h3C);
    busRead(12'h004, d); chk("R10 status kept", d, 32'h44);
    busRead(12'hFE0, d); chk("R10 id kept", d, 32'h50);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    pushRx(8'h11);
    @(negedge clk);
    busAddr = 12'h008; busRd = 1'b1; rxValid = 1'b1; rxByte = 8'h22;
    #5 d = busRdata;
    chk("R11 old byte returned", d, 32'h11);
    @(negedge clk);
    busRd = 1'b0; rxValid = 1'b0;
    busRead(12'h010, d); chk("R11 pending kept", d, 32'h3);
    busRead(12'h004, d); chk("R11 held parity of old", d, 32'h50);
    busRead(12'h008, d); chk("R11 new byte", d, 32'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testRxAndIrq();
    testTx();
    testId();
    testUnmapped();
    testCollision();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule